// File: doc/BRIEF.md
# Block-Write Configuration Slave

This block is a two-wire serial bus slave that holds the six 8-bit configuration bytes of a clock generator. It answers only two kinds of frame.

A write frame is addressed to D2h. Its first two bytes are a command byte and a length byte. Both are acknowledged and both are discarded. The data bytes that follow fill the configuration bytes strictly upward from byte 0. The host may end the frame with STOP after any whole byte.

A read frame is addressed to D3h. The slave first sends a length byte of 6, then the six configuration bytes in rising order. It keeps sending while the host acknowledges.

SCL and SDA are sampled in the system clock domain through a synchronizer with edge detection. SDA is driven open-drain through a pull-low enable. The four latched frequency-select straps are shown, inverted, at fixed bit positions in the readback stream. The stored bytes leave the block on a flat bus.

Top module: `cfg_serial_slave`

## Requirements
- R1: Only the address bytes D2h (write) and D3h (read) are acknowledged. After any other address byte the slave does not acknowledge that byte or any later byte, and it leaves SDA released until the next START.
- R2: After reset, configuration byte 0 is 00h and bytes 1 to 5 are FFh (enables on, reserved bits 1). SDA is released.
- R3: In a write frame, the two bytes after the address are acknowledged and change no configuration byte.
- R4: Write data bytes load configuration bytes 0, 1, 2 and onward in order. A STOP after any whole byte keeps every byte already received. Byte k sits at `cfg_o[8k+7:8k]`.
- R5: Write data bytes after the sixth are acknowledged and discarded.
- R6: A read frame returns 06h first, then bytes 0 to 5. Any byte requested after those is FFh.
- R7: On readback, the inverted straps replace stored bits at fixed positions: strap 0 at byte 2 bit 7, strap 2 at byte 1 bit 7, strap 1 at byte 4 bit 3, and strap 3 at byte 4 bit 1. `cfg_o` keeps the stored values and is not affected by the straps.
- R8: A START in the middle of a frame restarts address decoding. The byte pointer goes back so that the next write data byte lands in byte 0.
- R9: When the host does not acknowledge a read byte, the slave releases SDA and sends nothing more until the next START.
- R10: The SDA pull-low enable changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock as seen on the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| sda_low_o | output | 1 | 1 pulls SDA low; 0 releases it |
| strap_fs | input | 4 | Latched frequency-select straps, bit n is strap n |
| cfg_o | output | 48 | Stored configuration bytes, byte k at bits 8k+7:8k |

## Verification
The assertions assume the bus follows the rules below:
- SCL holds each level for several system clocks more than the synchronizer latency.
- The host changes SDA only while SCL is low, except for START and STOP.
- The host never issues START or STOP while the slave pulls SDA low.

The bench host keeps to these rules. It spends five system clocks on every quarter of a bit. It moves SDA only in the middle of the SCL low phase. It always ends a read with a not-acknowledge before it sends STOP. Because of this, the slave has released SDA before any STOP or START.

// File: rtl/cfgs_pkg.sv
package cfgs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RX_ACK,
    ST_TX,
    ST_TX_ACK
  } link_st_e;

  // Fixed readback positions of the inverted straps, indexed by strap number.
  localparam logic [3:0][2:0] STRAP_BYTE = {3'd4, 3'd1, 3'd4, 3'd2};
  localparam logic [3:0][2:0] STRAP_BIT  = {3'd1, 3'd7, 3'd3, 3'd7};
  localparam int              NUM_STRAPS = 4;

endpackage

// File: rtl/cfgs_sync.sv
module cfgs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  localparam int MSB = STAGES - 1;

  logic [MSB:0] scl_q, sda_q;
  logic         scl_d, sda_d;
  logic         scl_s;

  generate
    if (STAGES > 1) begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_q <= '1;
          sda_q <= '1;
        end else begin
          scl_q <= {scl_q[MSB-1:0], scl_i};
          sda_q <= {sda_q[MSB-1:0], sda_i};
        end
      end
    end else begin : g_single
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_q <= '1;
          sda_q <= '1;
        end else begin
          scl_q <= scl_i;
          sda_q <= sda_i;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_q[MSB];
      sda_d <= sda_q[MSB];
    end
  end

  assign scl_s     = scl_q[MSB];
  assign sda_s     = sda_q[MSB];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/cfgs_link.sv
module cfgs_link
  import cfgs_pkg::*;
#(
  parameter int         NUM_REGS   = 6,
  parameter int         SKIP_BYTES = 2,
  parameter logic [6:0] DEV_ADDR   = 7'h69,
  parameter int         IDX_W      = 3,
  parameter int         SEL_W      = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sda_s,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_det,
  input  logic             stop_det,
  input  logic [7:0]       rd_byte,
  output logic [SEL_W-1:0] rd_sel,
  output logic             sda_low_o,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic [7:0]       wr_data
);
  localparam int WC_W   = $clog2(SKIP_BYTES + NUM_REGS + 1);
  localparam int WC_MAX = SKIP_BYTES + NUM_REGS;

  link_st_e         state;
  logic [3:0]       bit_cnt;
  logic [7:0]       rx_sh;
  logic [7:0]       tx_sh;
  logic             first_byte;
  logic             rnw;
  logic             host_ack;
  logic [WC_W-1:0]  wcnt;
  logic             in_window;

  assign in_window = (wcnt >= WC_W'(SKIP_BYTES)) && (wcnt < WC_W'(WC_MAX));

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      bit_cnt    <= '0;
      rx_sh      <= '0;
      tx_sh      <= '0;
      first_byte <= 1'b0;
      rnw        <= 1'b0;
      host_ack   <= 1'b0;
      wcnt       <= '0;
      rd_sel     <= '0;
      sda_low_o  <= 1'b0;
      wr_en      <= 1'b0;
      wr_idx     <= '0;
      wr_data    <= '0;
    end else begin
      wr_en <= 1'b0;
      if (start_det) begin
        state      <= ST_RX;
        first_byte <= 1'b1;
        bit_cnt    <= '0;
        wcnt       <= '0;
        rd_sel     <= '0;
        sda_low_o  <= 1'b0;
      end else if (stop_det) begin
        state     <= ST_IDLE;
        sda_low_o <= 1'b0;
      end else begin
        unique case (state)
          ST_RX: begin
            if (scl_rise && bit_cnt != 4'd8) begin
              rx_sh   <= {rx_sh[6:0], sda_s};
              bit_cnt <= bit_cnt + 4'd1;
            end else if (scl_fall && bit_cnt == 4'd8) begin
              bit_cnt    <= '0;
              first_byte <= 1'b0;
              if (first_byte) begin
                if (rx_sh[7:1] == DEV_ADDR) begin
                  rnw       <= rx_sh[0];
                  sda_low_o <= 1'b1;
                  state     <= ST_RX_ACK;
                end else begin
                  state <= ST_IDLE;
                end
              end else begin
                sda_low_o <= 1'b1;
                state     <= ST_RX_ACK;
                if (in_window) begin
                  wr_en   <= 1'b1;
                  wr_idx  <= IDX_W'(wcnt - WC_W'(SKIP_BYTES));
                  wr_data <= rx_sh;
                end
                if (wcnt != WC_W'(WC_MAX)) wcnt <= wcnt + 1'b1;
              end
            end
          end
          ST_RX_ACK: begin
            if (scl_fall) begin
              if (rnw) begin
                tx_sh     <= rd_byte;
                sda_low_o <= ~rd_byte[7];
                bit_cnt   <= '0;
                state     <= ST_TX;
              end else begin
                sda_low_o <= 1'b0;
                state     <= ST_RX;
              end
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (bit_cnt == 4'd7) begin
                sda_low_o <= 1'b0;
                bit_cnt   <= '0;
                state     <= ST_TX_ACK;
              end else begin
                bit_cnt   <= bit_cnt + 4'd1;
                tx_sh     <= {tx_sh[6:0], 1'b0};
                sda_low_o <= ~tx_sh[6];
              end
            end
          end
          ST_TX_ACK: begin
            if (scl_rise) begin
              host_ack <= ~sda_s;
              if (!sda_s && rd_sel != SEL_W'(NUM_REGS + 1)) rd_sel <= rd_sel + 1'b1;
            end else if (scl_fall) begin
              if (host_ack) begin
                tx_sh     <= rd_byte;
                sda_low_o <= ~rd_byte[7];
                bit_cnt   <= '0;
                state     <= ST_TX;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/cfgs_regs.sv
module cfgs_regs
  import cfgs_pkg::*;
#(
  parameter int NUM_REGS = 6,
  parameter int IDX_W    = 3,
  parameter int SEL_W    = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [IDX_W-1:0]      wr_idx,
  input  logic [7:0]            wr_data,
  input  logic [SEL_W-1:0]      rd_sel,
  input  logic [3:0]            strap_fs,
  output logic [NUM_REGS*8-1:0] cfg_o,
  output logic [7:0]            rd_byte
);
  logic [NUM_REGS-1:0][7:0] mem;
  logic [NUM_REGS-1:0][7:0] view;

  always_ff @(posedge clk) begin
    for (int k = 0; k < NUM_REGS; k++) begin
      if (rst) mem[k] <= (k == 0) ? 8'h00 : 8'hFF;
      else if (wr_en && wr_idx == IDX_W'(k)) mem[k] <= wr_data;
    end
  end

  assign cfg_o = mem;

  // Readback view: straps override stored bits, inverted.
  always_comb begin
    view = mem;
    for (int s = 0; s < NUM_STRAPS; s++) begin
      for (int k = 0; k < NUM_REGS; k++) begin
        if (STRAP_BYTE[s] == 3'(k)) view[k][STRAP_BIT[s]] = ~strap_fs[s];
      end
    end
  end

  always_comb begin
    rd_byte = 8'hFF;
    if (rd_sel == '0) rd_byte = 8'(NUM_REGS);
    for (int k = 0; k < NUM_REGS; k++) begin
      if (rd_sel == SEL_W'(k + 1)) rd_byte = view[k];
    end
  end

endmodule

// File: rtl/cfg_serial_slave.sv
module cfg_serial_slave
  import cfgs_pkg::*;
#(
  parameter int         NUM_REGS    = 6,
  parameter int         SKIP_BYTES  = 2,
  parameter int         SYNC_STAGES = 2,
  parameter logic [6:0] DEV_ADDR    = 7'h69
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_low_o,
  input  logic [3:0]            strap_fs,
  output logic [NUM_REGS*8-1:0] cfg_o
);
  localparam int IDX_W = $clog2(NUM_REGS);
  localparam int SEL_W = $clog2(NUM_REGS + 2);

  logic             sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic             wr_en;
  logic [IDX_W-1:0] wr_idx;
  logic [7:0]       wr_data;
  logic [SEL_W-1:0] rd_sel;
  logic [7:0]       rd_byte;

  cfgs_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  cfgs_link #(
    .NUM_REGS(NUM_REGS), .SKIP_BYTES(SKIP_BYTES), .DEV_ADDR(DEV_ADDR),
    .IDX_W(IDX_W), .SEL_W(SEL_W)
  ) u_link (
    .clk(clk), .rst(rst), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .rd_byte(rd_byte), .rd_sel(rd_sel), .sda_low_o(sda_low_o),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data)
  );

  cfgs_regs #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W), .SEL_W(SEL_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_sel(rd_sel), .strap_fs(strap_fs), .cfg_o(cfg_o), .rd_byte(rd_byte)
  );

endmodule

// File: rtl/cfgs_checker.sv
module cfgs_checker #(
  parameter int NUM_REGS = 6,
  parameter int IDX_W    = 3
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  scl_i,
  input logic                  sda_low_o,
  input logic [NUM_REGS*8-1:0] cfg_o,
  input logic                  wr_en,
  input logic [IDX_W-1:0]      wr_idx
);
  localparam logic [NUM_REGS*8-1:0] DEFAULT_CFG = {{((NUM_REGS-1)*8){1'b1}}, 8'h00};

  a_r2_defaults_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cfg_o == DEFAULT_CFG && !sda_low_o));

  a_r4_cfg_moves_while_acking: assert property (@(posedge clk) disable iff (rst)
    !$stable(cfg_o) |-> sda_low_o);

  a_r5_write_index_in_range: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (wr_idx < IDX_W'(NUM_REGS)));

  a_r10_sda_moves_scl_low: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_low_o) |-> !scl_i);

endmodule

bind cfg_serial_slave cfgs_checker #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .scl_i(scl_i), .sda_low_o(sda_low_o),
  .cfg_o(cfg_o), .wr_en(wr_en), .wr_idx(wr_idx)
);

// File: tb/test_cfg_serial_slave.sv
module test_cfg_serial_slave;
  localparam int Q = 5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        scl_m = 1'b1;
  logic        sda_m = 1'b1;
  logic        sda_low_o;
  logic        sda_bus;
  logic [3:0]  strap_fs = 4'b0000;
  logic [47:0] cfg_o;

  int total = 0;
  int bad = 0;
  int sda_viol = 0;
  logic prev_low = 1'b0;
  logic [7:0] exp_reg [6];

  always #10 clk = ~clk;

  assign sda_bus = sda_m & ~sda_low_o;

  cfg_serial_slave i_cfg_serial_slave (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_low_o(sda_low_o), .strap_fs(strap_fs), .cfg_o(cfg_o)
  );

  // R10 monitor: pull-low enable must not move while SCL is high
  always @(negedge clk) begin
    if (!rst && sda_low_o != prev_low && scl_m) sda_viol++;
    prev_low = sda_low_o;
  end

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: run did not end, act=hung exp=done");
    summary();
  end

  task automatic chk(input string req, input logic [47:0] act, input logic [47:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [47:0] exp_cfg();
    logic [47:0] v;
    for (int k = 0; k < 6; k++) v[k*8 +: 8] = exp_reg[k];
    return v;
  endfunction

  function automatic logic [7:0] exp_view(input int k, input logic [3:0] s);
    logic [7:0] v;
    v = exp_reg[k];
    if (k == 1) v[7] = ~s[2];
    if (k == 2) v[7] = ~s[0];
    if (k == 4) begin v[3] = ~s[1]; v[1] = ~s[3]; end
    return v;
  endfunction

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    wclk(Q); sda_m = 1'b1; wclk(Q); scl_m = 1'b1; wclk(2*Q);
    sda_m = 1'b0; wclk(2*Q); scl_m = 1'b0;
  endtask

  task automatic bus_stop();
    wclk(Q); sda_m = 1'b0; wclk(Q); scl_m = 1'b1; wclk(2*Q);
    sda_m = 1'b1; wclk(2*Q);
  endtask

  task automatic send_bit(input logic b);
    wclk(Q); sda_m = b; wclk(Q); scl_m = 1'b1; wclk(2*Q); scl_m = 1'b0;
  endtask

  task automatic get_bit(output logic b);
    wclk(Q); sda_m = 1'b1; wclk(Q); scl_m = 1'b1; wclk(Q);
    b = sda_bus; wclk(Q); scl_m = 1'b0;
  endtask

  task automatic wr_byte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    get_bit(b);
    ack = ~b;
  endtask

  task automatic rd_byte(output logic [7:0] d, input logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) begin get_bit(b); d[i] = b; end
    send_bit(~ack);
  endtask

  // Write frame with n data bytes; bytes past the sixth must still be acked (R5)
  task automatic do_write(input int n, input logic [7:0] base);
    logic ack;
    logic [7:0] d;
    bus_start();
    wr_byte(8'hD2, ack); chk("R1 write address ack", 48'(ack), 48'd1);
    wr_byte(8'hA5, ack); chk("R3 command ack", 48'(ack), 48'd1);
    wr_byte(8'h5A, ack); chk("R3 count ack", 48'(ack), 48'd1);
    for (int i = 0; i < n; i++) begin
      d = base + 8'(i * 29);
      wr_byte(d, ack);
      if (i < 6) begin
        exp_reg[i] = d;
        chk("R4 data ack", 48'(ack), 48'd1);
      end else begin
        chk("R5 extra data ack", 48'(ack), 48'd1);
      end
    end
    bus_stop();
    chk("R4 R3 R5 stored bytes", cfg_o, exp_cfg());
  endtask

  task automatic do_read();
    logic ack;
    logic [7:0] d;
    bus_start();
    wr_byte(8'hD3, ack); chk("R1 read address ack", 48'(ack), 48'd1);
    rd_byte(d, 1'b1);    chk("R6 length byte", 48'(d), 48'h06);
    for (int k = 0; k < 6; k++) begin
      rd_byte(d, 1'b1);
      chk("R6 R7 readback byte", 48'(d), 48'(exp_view(k, strap_fs)));
    end
    rd_byte(d, 1'b0);    chk("R6 byte past end", 48'(d), 48'hFF);
    bus_stop();
    chk("R7 cfg_o ignores straps", cfg_o, exp_cfg());
  endtask

  initial begin
    logic ack;
    logic [7:0] d;
    for (int k = 0; k < 6; k++) exp_reg[k] = (k == 0) ? 8'h00 : 8'hFF;
    wclk(5);
    rst = 1'b0;
    wclk(3);
    chk("R2 reset defaults", cfg_o, 48'hFFFF_FFFF_FF00);
    chk("R2 SDA released", 48'(sda_low_o), 48'd0);

    strap_fs = 4'b0101;
    do_read();

    // R1: sweep every address byte except the read address
    for (int a = 0; a < 256; a++) begin
      if (a != 8'hD3) begin
        bus_start();
        wr_byte(8'(a), ack);
        chk("R1 address decode", 48'(ack), (a == 8'hD2) ? 48'd1 : 48'd0);
        bus_stop();
      end
    end
    bus_start();
    wr_byte(8'hA4, ack);
    wr_byte(8'h00, ack); chk("R1 no ack after foreign address", 48'(ack), 48'd0);
    bus_stop();
    chk("R1 foreign frame changes nothing", cfg_o, exp_cfg());

    // R4 R5: data lengths 0 to 8
    for (int n = 0; n <= 8; n++) do_write(n, 8'(n * 17 + 3));
    do_read();

    // R8: repeated START resets the pointer
    bus_start();
    wr_byte(8'hD2, ack); wr_byte(8'h00, ack); wr_byte(8'h00, ack);
    wr_byte(8'h3C, ack);
    bus_start();
    wr_byte(8'hD2, ack); chk("R8 address after restart", 48'(ack), 48'd1);
    wr_byte(8'h11, ack); wr_byte(8'h22, ack);
    wr_byte(8'hC3, ack);
    bus_stop();
    exp_reg[0] = 8'hC3;
    chk("R8 restart rewrites byte 0", cfg_o, exp_cfg());

    // R7: all strap combinations
    for (int s = 0; s < 16; s++) begin
      strap_fs = 4'(s);
      do_read();
    end

    // R9: host refuses the first byte
    bus_start();
    wr_byte(8'hD3, ack);
    rd_byte(d, 1'b0);    chk("R9 length before nack", 48'(d), 48'h06);
    wclk(Q);
    chk("R9 SDA released after nack", 48'(sda_bus), 48'd1);
    for (int i = 7; i >= 0; i--) begin logic b; get_bit(b); d[i] = b; end
    chk("R9 slave silent after nack", 48'(d), 48'hFF);
    bus_stop();
    do_read();

    chk("R10 SDA moved only with SCL low", 48'(sda_viol), 48'd0);
    summary();
  end

endmodule